// File: doc/BRIEF.md
# Balanced Ternary Sequential Multiplier

This block multiplies two signed balanced ternary words of `TRITS` trits each and returns the exact product as a word of twice that many trits. Every trit travels as a two-bit code, the same code a balanced ternary adder in the same library uses, so operands and results can pass between the two blocks without conversion.

The multiply is iterative. A start pulse loads both operands and clears the accumulator. From then on the block handles one trit of the second operand (the multiplier) per clock, starting at the least significant trit. It adds the first operand (the multiplicand), shifted to the current trit position, to the accumulator when that trit is +1. It adds the trit-wise inverted multiplicand when the trit is −1. It leaves the accumulator untouched when the trit is 0. The shift moves the multiplicand up by one whole trit, which is two bits of the code. The sum runs through a ripple chain of balanced ternary full-adder cells.

A busy flag covers the run. A one-cycle done pulse marks the point where the product is final, and the product then stays on the output until the next accepted start.

Top module: `bt_shift_mul`

## Requirements
- R1: Each trit is coded in two bits: 2'b00 means 0, 2'b01 means +1 and 2'b10 means −1. Trit i of a word occupies bits [2i+1:2i], so the least significant trit sits at bit 0. A finished product contains no 2'b11 code.
- R2: While reset is held and right after it, busy and done are low and every bit of the product is zero.
- R3: When done is high, the product equals the exact value of a_in × b_in coded in 2·TRITS trits, with no wrap and no overflow. For example, 13 × 7 gives 91, which is trits +0+0+ read from the most significant end.
- R4: A start while busy is low is accepted on that clock edge. After that edge busy is high and the product reads zero.
- R5: done is high for exactly one cycle. It comes TRITS clock edges after the accepting edge, and busy falls on the same edge that raises done.
- R6: A start while busy is high is ignored. The running multiply keeps its operands and its timing, and the new operands are not used.
- R7: While busy is low and no start arrives, the product holds its value.
- R8: A start given in the cycle where done is high is accepted, so two multiplies can run back to back with no idle cycle between them.
- R9: A multiplier trit of 0 leaves the accumulator unchanged in its cycle, so the product reads zero until the first nonzero multiplier trit has been used.
- R10: A multiplier trit of −1 adds the multiplicand with every trit inverted (+1 and −1 swapped), with no further correction. Multiplying by −1 therefore returns the exact negation of the multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; sampled only while idle |
| a_in | input | 2·TRITS | Multiplicand, balanced ternary |
| b_in | input | 2·TRITS | Multiplier, balanced ternary |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 4·TRITS | Accumulator; holds the exact product after done |

## Verification
Two events can fall in the same cycle: the completion of one multiply, shown by the done pulse, and the acceptance of the next start. The bench provokes this by raising start with fresh operands in exactly the cycle where done is observed. It then checks two things: that the first product was correct in that cycle, and that the second multiply finishes TRITS cycles later with its own exact product. A second kind of overlap is a start raised in the middle of a run. The bench judges it by requiring that neither the latency nor the final product of the running multiply changes.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef logic [1:0] trit_t;

   localparam trit_t TRIT_Z = 2'b00;
   localparam trit_t TRIT_P = 2'b01;
   localparam trit_t TRIT_N = 2'b10;

   // swap of the two code bits turns +1 into -1 and back, 0 stays 0
   function automatic trit_t trit_flip(trit_t t);
      return {t[0], t[1]};
   endfunction

   function automatic int trit_to_int(trit_t t);
      if (t == TRIT_P) return 1;
      if (t == TRIT_N) return -1;
      return 0;
   endfunction

   function automatic trit_t int_to_trit(int v);
      if (v > 0) return TRIT_P;
      if (v < 0) return TRIT_N;
      return TRIT_Z;
   endfunction
endpackage

// File: rtl/bt_trit_fa.sv
module bt_trit_fa
   import bt_pkg::*;
(
   input  trit_t x,
   input  trit_t y,
   input  trit_t cin,
   output trit_t s,
   output trit_t cout
);
   int total;

   always_comb begin
      total = trit_to_int(x) + trit_to_int(y) + trit_to_int(cin);
      if (total > 1) begin
         cout = TRIT_P;
         s    = int_to_trit(total - 3);
      end else if (total < -1) begin
         cout = TRIT_N;
         s    = int_to_trit(total + 3);
      end else begin
         cout = TRIT_Z;
         s    = int_to_trit(total);
      end
   end
endmodule

// File: rtl/bt_ripple_add.sv
module bt_ripple_add
   import bt_pkg::*;
#(
   parameter int WIDTH = 16
)(
   input  logic [2*WIDTH-1:0] x,
   input  logic [2*WIDTH-1:0] y,
   output logic [2*WIDTH-1:0] sum,
   output trit_t              cout
);
   localparam int CBITS = 2*WIDTH + 2;

   logic [CBITS-1:0] carry;

   assign carry[1:0] = TRIT_Z;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      bt_trit_fa u_fa (
         .x   (x[2*i +: 2]),
         .y   (y[2*i +: 2]),
         .cin (carry[2*i +: 2]),
         .s   (sum[2*i +: 2]),
         .cout(carry[2*i+2 +: 2])
      );
   end

   assign cout = carry[CBITS-1 -: 2];
endmodule

// File: rtl/bt_pp_select.sv
module bt_pp_select
   import bt_pkg::*;
#(
   parameter int WIDTH = 16
)(
   input  logic [2*WIDTH-1:0] mcand,
   input  trit_t              sel,
   output logic [2*WIDTH-1:0] addend
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_trit
      always_comb begin
         unique case (sel)
            TRIT_P:  addend[2*i +: 2] = mcand[2*i +: 2];
            TRIT_N:  addend[2*i +: 2] = trit_flip(mcand[2*i +: 2]);
            default: addend[2*i +: 2] = TRIT_Z;
         endcase
      end
   end
endmodule

// File: rtl/bt_mul_ctrl.sv
module bt_mul_ctrl #(
   parameter int STEPS = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic busy,
   output logic done
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;
   logic          last;

   assign accept = start && !busy;
   assign last   = busy && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= last;
         if (accept) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (last) begin
            busy  <= 1'b0;
         end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bt_shift_mul.sv
module bt_shift_mul
   import bt_pkg::*;
#(
   parameter int TRITS = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2*TRITS-1:0] a_in,
   input  logic [2*TRITS-1:0] b_in,
   output logic               busy,
   output logic               done,
   output logic [4*TRITS-1:0] product
);
   localparam int OP_BITS   = 2*TRITS;
   localparam int PROD_TRIT = 2*TRITS;
   localparam int PROD_BITS = 2*PROD_TRIT;

   if (TRITS < 2) begin : g_bad_trits
      $error("bt_shift_mul: TRITS must be at least 2");
   end

   logic                 accept;
   logic [PROD_BITS-1:0] mcand_q;
   logic [OP_BITS-1:0]   mplier_q;
   logic [PROD_BITS-1:0] acc_q;
   logic [PROD_BITS-1:0] addend;
   logic [PROD_BITS-1:0] acc_next;
   trit_t                add_cout;
   trit_t                cur;

   assign cur = mplier_q[1:0];

   bt_mul_ctrl #(.STEPS(TRITS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .accept(accept),
      .busy  (busy),
      .done  (done)
   );

   bt_pp_select #(.WIDTH(PROD_TRIT)) u_pp (
      .mcand (mcand_q),
      .sel   (cur),
      .addend(addend)
   );

   bt_ripple_add #(.WIDTH(PROD_TRIT)) u_add (
      .x   (acc_q),
      .y   (addend),
      .sum (acc_next),
      .cout(add_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (accept) begin
         mcand_q  <= {{(PROD_BITS-OP_BITS){1'b0}}, a_in};
         mplier_q <= b_in;
         acc_q    <= '0;
      end else if (busy) begin
         mcand_q  <= {mcand_q[PROD_BITS-3:0], TRIT_Z};
         mplier_q <= {TRIT_Z, mplier_q[OP_BITS-1:2]};
         if (cur == TRIT_P || cur == TRIT_N) begin
            acc_q <= acc_next;
         end
      end
   end

   assign product = acc_q;
endmodule

// File: rtl/bt_shift_mul_chk.sv
module bt_shift_mul_chk #(
   parameter int TRITS = 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [4*TRITS-1:0] product,
   input logic [1:0]         add_cout
);
   int   run_cnt;
   logic bad_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_cnt <= 0;
      else if (start && !busy)  run_cnt <= 0;
      else if (busy)            run_cnt <= run_cnt + 1;
   end

   always_comb begin
      bad_code = 1'b0;
      for (int i = 0; i < 2*TRITS; i++) begin
         if (product[2*i +: 2] == 2'b11) bad_code = 1'b1;
      end
   end

   p_code_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bad_code);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> add_cout == 2'b00);

   p_busy_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy && product == '0);

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == TRITS) && !busy);

   p_busy_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt < TRITS);

   p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && run_cnt < TRITS - 1) |=> busy && run_cnt == $past(run_cnt) + 1);

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));

   p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> busy && run_cnt == 0);
endmodule

bind bt_shift_mul bt_shift_mul_chk #(.TRITS(TRITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product),
   .add_cout(add_cout)
);

// File: tb/tb_bt_shift_mul.sv
module tb_bt_shift_mul;
   localparam int T     = 8;
   localparam int OPB   = 2*T;
   localparam int PRB   = 4*T;
   localparam int LIMIT = 200000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [OPB-1:0] a_in = '0;
   logic [OPB-1:0] b_in = '0;
   logic           busy;
   logic           done;
   logic [PRB-1:0] product;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   longint max_op;

   always #2 clk = ~clk;

   bt_shift_mul #(.TRITS(T)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy), .done(done), .product(product)
   );

   // code: 00 zero, 01 plus, 10 minus; trit i at bits [2i+1:2i]
   function automatic logic [PRB-1:0] enc(longint v, int ntr);
      logic [PRB-1:0] r = '0;
      longint x = v;
      for (int i = 0; i < ntr; i++) begin
         longint m = x % 3;
         if (m < 0) m += 3;
         if (m == 1) begin r[2*i +: 2] = 2'b01; x = (x - 1) / 3; end
         else if (m == 2) begin r[2*i +: 2] = 2'b10; x = (x + 1) / 3; end
         else x = x / 3;
      end
      return r;
   endfunction

   function automatic longint dec(logic [PRB-1:0] w);
      longint v = 0;
      for (int i = 2*T - 1; i >= 0; i--) begin
         v = v * 3;
         if (w[2*i +: 2] == 2'b01) v = v + 1;
         else if (w[2*i +: 2] == 2'b10) v = v - 1;
      end
      return v;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic launch(longint a, longint b);
      a_in  = enc(a, T)[OPB-1:0];
      b_in  = enc(b, T)[OPB-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 4*T) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_mul(longint a, longint b, string req);
      int lat;
      logic [PRB-1:0] held;
      launch(a, b);
      check(busy === 1'b1 && product === '0, "R4 accept", longint'(busy), 1);
      wait_done(lat);
      check(lat == T, "R5 latency", lat, T);
      check(busy === 1'b0, "R5 busy falls with done", longint'(busy), 0);
      check(product === enc(a * b, 2*T), req, dec(product), a * b);
      held = product;
      @(negedge clk);
      check(done === 1'b0, "R5 single cycle done", longint'(done), 0);
      check(product === held, "R7 hold", dec(product), dec(held));
   endtask

   initial begin
      int lat;
      longint a, b, c, d;
      logic [PRB-1:0] pr;
      max_op = 1;
      for (int i = 0; i < T; i++) max_op = max_op * 3;
      max_op = (max_op - 1) / 2;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R2 reset flags", longint'(busy), 0);
      check(product === '0, "R2 reset product", dec(product), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && product === '0, "R2 after release", dec(product), 0);

      // R3 directed: 13 x 7 = 91 (+0+0+)
      run_mul(13, 7, "R3 13x7");
      check(product[9:0] === 10'b01_00_01_00_01, "R1 code of 91", dec(product), 91);
      run_mul(max_op, max_op, "R3 max x max");
      run_mul(-max_op, max_op, "R3 min x max");
      run_mul(-max_op, -max_op, "R3 min x min");
      run_mul(1234, -1, "R10 negate by minus one");
      run_mul(-777, 1, "R3 times plus one");
      run_mul(0, 2500, "R3 zero multiplicand");

      // R9: multiplier 0 keeps product zero every cycle
      launch(321, 0);
      for (int k = 0; k < T; k++) begin
         check(product === '0, "R9 zero multiplier", dec(product), 0);
         @(negedge clk);
      end
      check(done === 1'b1 && product === '0, "R9 zero result", dec(product), 0);
      @(negedge clk);

      // R9: multiplier 9 = trits 0,0,+ : product zero for two steps
      launch(50, 9);
      @(negedge clk);
      check(product === '0, "R9 first zero trit", dec(product), 0);
      @(negedge clk);
      check(product === '0, "R9 second zero trit", dec(product), 0);
      @(negedge clk);
      check(product === enc(450, 2*T), "R9 first nonzero trit", dec(product), 450);
      wait_done(lat);
      check(product === enc(450, 2*T), "R3 50x9", dec(product), 450);
      @(negedge clk);

      // R6: start mid-run with other operands is ignored
      launch(-200, 37);
      repeat (3) @(negedge clk);
      a_in = enc(99, T)[OPB-1:0];
      b_in = enc(99, T)[OPB-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R6 busy kept", longint'(busy), 1);
      wait_done(lat);
      check(lat == T - 4, "R6 timing kept", lat, T - 4);
      check(product === enc(-7400, 2*T), "R6 operands kept", dec(product), -7400);
      @(negedge clk);
      check(busy === 1'b0, "R6 no extra run", longint'(busy), 0);

      // R8: start during done cycle
      launch(111, -222);
      wait_done(lat);
      check(product === enc(-24642, 2*T), "R8 first product", dec(product), -24642);
      launch(-3000, 3001);
      check(busy === 1'b1, "R8 accepted at done", longint'(busy), 1);
      wait_done(lat);
      check(lat == T, "R8 second latency", lat, T);
      check(product === enc(-9003000, 2*T), "R8 second product", dec(product), -9003000);
      @(negedge clk);

      // random operands
      for (int n = 0; n < 60; n++) begin
         a = longint'($urandom_range(0, 2*max_op)) - max_op;
         b = longint'($urandom_range(0, 2*max_op)) - max_op;
         launch(a, b);
         wait_done(lat);
         pr = enc(a * b, 2*T);
         check(lat == T && product === pr, "R3 random", dec(product), a * b);
         if ($urandom_range(0, 1) == 1) begin
            c = longint'($urandom_range(0, 2*max_op)) - max_op;
            d = longint'($urandom_range(0, 2*max_op)) - max_op;
            launch(c, d);
            wait_done(lat);
            check(product === enc(c * d, 2*T), "R8 random back to back", dec(product), c * d);
         end
         repeat ($urandom_range(1, 3)) @(negedge clk);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule